// File: doc/BRIEF.md
# Reversible Two-Lane Router Link Controller

This block sits at one end of the connection between two neighbouring mesh routers. The connection has two lanes, and the near end or the far end can drive either one. Because a lane can turn around at runtime, a direction can get no lane, one lane or both lanes. A direction can therefore be doubled when the traffic is lopsided. A healthy lane can also take over the direction of a lane that has failed. The block reads the requested, available and used bandwidth for each direction together with a fault flag per lane. From these it decides whether a lane turns around. It produces the two drive selects of each lane and moves flits between the local buffers and the lanes through a one-stage register per lane.

A lane only turns around after it has drained. Once a turn is chosen, the lane accepts no new flits. The block waits until the lane's stage register is empty, then spends one cycle in which neither end drives, and only then flips the lane. The routing logic also receives the number of lanes facing each way and a flag that a direction has doubled capacity.

Top module: `revlink_top`

## Requirements
- R1: After reset, lane 0 faces outward and lane 1 faces inward: `laneSel` = 4'b1001, `linkMode` = 1, `capOut` = `capIn` = 1, both doubling flags are 0, `cfgErr` = 0 and `txReady` = 2'b01.
- R2: `laneSel[k]` is the near-end drive select of lane k and `laneSel[k+2]` its far-end select; 1 means that end drives the lane. The two selects of a lane are never 1 together. On a healthy lane that is not turning around, exactly one of them is 1, and the near select is 1 exactly when the lane faces outward.
- R3: In the idle state, the block turns the lowest-index healthy inward lane outward when `availOut < reqOut` and `usedIn == 0`. Otherwise, when `availIn < reqIn` and `usedOut == 0`, it turns the lowest-index healthy outward lane inward. When neither condition holds, no lane changes.
- R4: Once a turn is chosen, `txReady` of that lane is 0 until the turn completes. The block waits until the lane's stage register is empty. It then holds both selects of the lane at 0 for exactly one cycle, and in the next cycle the lane shows its new direction. With an empty lane, the new direction appears two cycles after the edge that accepted the request.
- R5: While `laneFault[k]` is 1, both selects of lane k are 0, `txReady[k]` and `rxValid[k]` are 0, and the lane drops out of `capOut` and `capIn`. All of this takes effect in the same cycle the fault input rises.
- R6: When a lane is faulted and a healthy lane faces the opposite way, the healthy lane is turned to the faulted lane's direction, provided the usage figure for its current direction is 0. This rule takes precedence over R3.
- R7: An override on `ovrValid` carries requested selects in `ovrSel` with the layout of `laneSel`. If any lane would have both ends at 1, `cfgErr` is 1 in the following cycle and the configuration does not change. A legal override in the idle state sets each lane whose two requested bits differ, and it takes precedence over R3 and R6. Overrides arriving while a turn is in progress are ignored.
- R8: `linkMode` is the number of outward-facing lanes (0 all inward, 1 split, 2 all outward). `capOut` and `capIn` count the healthy lanes in each direction. `rOutDbl` and `rInDbl` are 1 exactly when that count is 2.
- R9: A flit accepted with `txValid` and `txReady` appears on `laneTxValid` and `laneTxData` one cycle later. A flit arriving with `farValid` on a healthy inward lane appears on `rxValid` and `rxData` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| laneFault | input | 2 | Per-lane unusable flag |
| availOut | input | BW_W | Available bandwidth toward the neighbour |
| reqOut | input | BW_W | Requested bandwidth toward the neighbour |
| usedOut | input | BW_W | Used bandwidth toward the neighbour |
| availIn | input | BW_W | Available bandwidth toward this router |
| reqIn | input | BW_W | Requested bandwidth toward this router |
| usedIn | input | BW_W | Used bandwidth toward this router |
| ovrValid | input | 1 | Override request strobe |
| ovrSel | input | 4 | Requested drive selects, same layout as laneSel |
| txValid | input | 2 | Local buffer has a flit for lane k |
| txData | input | 2*FLIT_W | Local flits, lane k at bits k*FLIT_W |
| txReady | output | 2 | Lane k takes a local flit this cycle |
| farValid | input | 2 | Neighbour drives a flit on lane k |
| farData | input | 2*FLIT_W | Neighbour flits per lane |
| laneSel | output | 4 | Drive selects: [1:0] near end, [3:2] far end |
| laneTxValid | output | 2 | Flit driven outward on lane k |
| laneTxData | output | 2*FLIT_W | Outward flit data per lane |
| rxValid | output | 2 | Flit delivered to the local input decoder |
| rxData | output | 2*FLIT_W | Inward flit data per lane |
| capOut | output | 2 | Healthy lanes facing outward |
| capIn | output | 2 | Healthy lanes facing inward |
| rOutDbl | output | 1 | Outward capacity is doubled |
| rInDbl | output | 1 | Inward capacity is doubled |
| linkMode | output | 2 | Outward-facing lane count |
| cfgErr | output | 1 | Illegal override seen in the previous cycle |

## Verification
The assertions check on every cycle that no lane is driven from both ends, that a lane never flips without a cycle in which nobody drives it, and that a faulted lane is parked. They also check that an illegal override raises the error flag, that an accepted flit is on the lane one cycle later, and that the two doubling flags never hold together. Only the bench's scenarios can show the decision behaviour. That covers which lane is picked under each combination of bandwidth conditions and starting direction, the extra cycle spent draining a loaded lane, the priority of fault takeover, and that overrides are ignored while a turn is in progress.

// File: rtl/revlink_pkg.sv
package revlink_pkg;
  localparam int LANES = 2;
  localparam int CW = $clog2(LANES + 1);

  typedef struct packed {
    logic [LANES-1:0] dirOut;  // 1: lane faces the neighbour
    logic [LANES-1:0] hold;    // stop loading new flits
    logic [LANES-1:0] turn;    // neither end drives
    logic [LANES-1:0] usable;  // lane healthy
  } lnkCtl_t;

  typedef enum logic [1:0] {ST_IDLE, ST_DRAIN, ST_TURN} revState_e;
endpackage

// File: rtl/revlink_ctl.sv
module revlink_ctl import revlink_pkg::*; #(
  parameter int BW_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LANES-1:0] laneFault,
  input  logic [BW_W-1:0]  availOut,
  input  logic [BW_W-1:0]  reqOut,
  input  logic [BW_W-1:0]  usedOut,
  input  logic [BW_W-1:0]  availIn,
  input  logic [BW_W-1:0]  reqIn,
  input  logic [BW_W-1:0]  usedIn,
  input  logic             ovrValid,
  input  logic [2*LANES-1:0] ovrSel,
  input  logic [LANES-1:0] busy,
  output lnkCtl_t          ctl,
  output logic             cfgErr,
  output logic [CW-1:0]    capOut,
  output logic [CW-1:0]    capIn,
  output logic             rOutDbl,
  output logic             rInDbl,
  output logic [CW-1:0]    linkMode
);
  function automatic logic [LANES-1:0] lowBit(input logic [LANES-1:0] v);
    return v & (~v + 1'b1);
  endfunction

  revState_e        stQ;
  logic [LANES-1:0] dirQ, maskQ, newDirQ;
  logic [LANES-1:0] usable, ovrNear, ovrFar, ovrMask, takeCand, candOut, candIn;
  logic [LANES-1:0] reqMask, reqDir;
  logic             ovrBad, needOut, needIn;

  assign usable  = ~laneFault;
  assign ovrNear = ovrSel[LANES-1:0];
  assign ovrFar  = ovrSel[2*LANES-1:LANES];
  assign ovrBad  = |(ovrNear & ovrFar);
  assign ovrMask = (ovrNear ^ ovrFar) & (ovrNear ^ dirQ);
  assign needOut = (availOut < reqOut) && (usedIn == '0);
  assign needIn  = (availIn < reqIn) && (usedOut == '0);
  assign candOut = usable & ~dirQ;
  assign candIn  = usable & dirQ;

  always_comb begin
    takeCand = '0;
    for (int j = 0; j < LANES; j++) begin
      for (int k = 0; k < LANES; k++) begin
        if (k != j && laneFault[k] && usable[j] && (dirQ[k] != dirQ[j]) &&
            (dirQ[j] ? (usedOut == '0) : (usedIn == '0)))
          takeCand[j] = 1'b1;
      end
    end
  end

  always_comb begin
    reqMask = '0;
    reqDir  = dirQ;
    if (ovrValid && !ovrBad && ovrMask != '0) begin
      reqMask = ovrMask;
      reqDir  = (dirQ & ~ovrMask) | (ovrNear & ovrMask);
    end else if (takeCand != '0) begin
      reqMask = lowBit(takeCand);
      reqDir  = dirQ ^ reqMask;
    end else if (needOut && candOut != '0) begin
      reqMask = lowBit(candOut);
      reqDir  = dirQ ^ reqMask;
    end else if (needIn && candIn != '0) begin
      reqMask = lowBit(candIn);
      reqDir  = dirQ ^ reqMask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ     <= ST_IDLE;
      dirQ    <= LANES'(1);
      maskQ   <= '0;
      newDirQ <= '0;
      cfgErr  <= 1'b0;
    end else begin
      cfgErr <= ovrValid && ovrBad;
      unique case (stQ)
        ST_IDLE: if (reqMask != '0) begin
          maskQ   <= reqMask;
          newDirQ <= reqDir;
          stQ     <= ST_DRAIN;
        end
        ST_DRAIN: if ((busy & maskQ) == '0) stQ <= ST_TURN;
        ST_TURN: begin
          dirQ  <= newDirQ;
          maskQ <= '0;
          stQ   <= ST_IDLE;
        end
        default: stQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    capOut   = '0;
    capIn    = '0;
    linkMode = '0;
    for (int k = 0; k < LANES; k++) begin
      capOut   = capOut + CW'(usable[k] & dirQ[k]);
      capIn    = capIn + CW'(usable[k] & ~dirQ[k]);
      linkMode = linkMode + CW'(dirQ[k]);
    end
  end

  assign rOutDbl    = (capOut == CW'(LANES));
  assign rInDbl     = (capIn == CW'(LANES));
  assign ctl.dirOut = dirQ;
  assign ctl.hold   = (stQ != ST_IDLE) ? maskQ : '0;
  assign ctl.turn   = (stQ == ST_TURN) ? maskQ : '0;
  assign ctl.usable = usable;
endmodule

// File: rtl/revlink_dp.sv
module revlink_dp import revlink_pkg::*; #(
  parameter int FLIT_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  lnkCtl_t                 ctl,
  input  logic [LANES-1:0]        txValid,
  input  logic [LANES*FLIT_W-1:0] txData,
  output logic [LANES-1:0]        txReady,
  input  logic [LANES-1:0]        farValid,
  input  logic [LANES*FLIT_W-1:0] farData,
  output logic [2*LANES-1:0]      laneSel,
  output logic [LANES-1:0]        laneTxValid,
  output logic [LANES*FLIT_W-1:0] laneTxData,
  output logic [LANES-1:0]        rxValid,
  output logic [LANES*FLIT_W-1:0] rxData,
  output logic [LANES-1:0]        busy
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic              stV, outAct, inAct, loadOut, loadIn;
    logic [FLIT_W-1:0] stD;

    assign outAct  = ctl.dirOut[g] & ctl.usable[g] & ~ctl.turn[g];
    assign inAct   = ~ctl.dirOut[g] & ctl.usable[g] & ~ctl.turn[g];
    assign txReady[g] = outAct & ~ctl.hold[g];
    assign loadOut = txValid[g] & txReady[g];
    assign loadIn  = farValid[g] & inAct & ~ctl.hold[g];

    always_ff @(posedge clk) begin
      if (!rstN || !ctl.usable[g]) stV <= 1'b0;
      else                         stV <= loadOut | loadIn;
      if (loadOut)     stD <= txData[g*FLIT_W +: FLIT_W];
      else if (loadIn) stD <= farData[g*FLIT_W +: FLIT_W];
    end

    // direction-selected mux standing in for the tri-state pair
    assign laneSel[g]         = outAct;
    assign laneSel[g + LANES] = inAct;
    assign laneTxValid[g]     = stV & outAct;
    assign laneTxData[g*FLIT_W +: FLIT_W] = outAct ? stD : '0;
    assign rxValid[g]         = stV & ~ctl.dirOut[g] & ctl.usable[g];
    assign rxData[g*FLIT_W +: FLIT_W]     = stD;
    assign busy[g]            = stV;
  end
endmodule

// File: rtl/revlink_top.sv
module revlink_top import revlink_pkg::*; #(
  parameter int FLIT_W = 16,
  parameter int BW_W   = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [LANES-1:0]        laneFault,
  input  logic [BW_W-1:0]         availOut,
  input  logic [BW_W-1:0]         reqOut,
  input  logic [BW_W-1:0]         usedOut,
  input  logic [BW_W-1:0]         availIn,
  input  logic [BW_W-1:0]         reqIn,
  input  logic [BW_W-1:0]         usedIn,
  input  logic                    ovrValid,
  input  logic [2*LANES-1:0]      ovrSel,
  input  logic [LANES-1:0]        txValid,
  input  logic [LANES*FLIT_W-1:0] txData,
  output logic [LANES-1:0]        txReady,
  input  logic [LANES-1:0]        farValid,
  input  logic [LANES*FLIT_W-1:0] farData,
  output logic [2*LANES-1:0]      laneSel,
  output logic [LANES-1:0]        laneTxValid,
  output logic [LANES*FLIT_W-1:0] laneTxData,
  output logic [LANES-1:0]        rxValid,
  output logic [LANES*FLIT_W-1:0] rxData,
  output logic [CW-1:0]           capOut,
  output logic [CW-1:0]           capIn,
  output logic                    rOutDbl,
  output logic                    rInDbl,
  output logic [CW-1:0]           linkMode,
  output logic                    cfgErr
);
  lnkCtl_t          ctl;
  logic [LANES-1:0] busy;

  revlink_ctl #(.BW_W(BW_W)) u_ctl (
    .clk(clk), .rstN(rstN), .laneFault(laneFault),
    .availOut(availOut), .reqOut(reqOut), .usedOut(usedOut),
    .availIn(availIn), .reqIn(reqIn), .usedIn(usedIn),
    .ovrValid(ovrValid), .ovrSel(ovrSel), .busy(busy),
    .ctl(ctl), .cfgErr(cfgErr), .capOut(capOut), .capIn(capIn),
    .rOutDbl(rOutDbl), .rInDbl(rInDbl), .linkMode(linkMode)
  );

  revlink_dp #(.FLIT_W(FLIT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .txValid(txValid), .txData(txData), .txReady(txReady),
    .farValid(farValid), .farData(farData), .laneSel(laneSel),
    .laneTxValid(laneTxValid), .laneTxData(laneTxData),
    .rxValid(rxValid), .rxData(rxData), .busy(busy)
  );
endmodule

// File: rtl/revlink_chk.sv
module revlink_chk import revlink_pkg::*; (
  input logic               clk,
  input logic               rstN,
  input logic [LANES-1:0]   laneFault,
  input logic               ovrValid,
  input logic [2*LANES-1:0] ovrSel,
  input logic [LANES-1:0]   txValid,
  input logic [LANES-1:0]   txReady,
  input logic [2*LANES-1:0] laneSel,
  input logic [LANES-1:0]   laneTxValid,
  input logic [LANES-1:0]   rxValid,
  input logic [CW-1:0]      capIn,
  input logic               rOutDbl,
  input logic               cfgErr
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    // R2
    no_contention_chk: assert property (@(posedge clk) disable iff (!rstN)
      !(laneSel[g] && laneSel[g + LANES]));
    // R4
    turn_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
      laneSel[g] |-> !$past(laneSel[g + LANES]));
    // R5
    fault_park_chk: assert property (@(posedge clk) disable iff (!rstN)
      laneFault[g] |-> (!laneSel[g] && !laneSel[g + LANES] && !txReady[g] && !rxValid[g]));
    // R9
    tx_pipe_chk: assert property (@(posedge clk) disable iff (!rstN)
      (txValid[g] && txReady[g]) |=> (laneTxValid[g] || laneFault[g]));
  end

  // R7
  ovr_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovrValid && |(ovrSel[LANES-1:0] & ovrSel[2*LANES-1:LANES])) |=> cfgErr);
  // R8
  dbl_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    rOutDbl |-> (capIn == '0));
endmodule

bind revlink_top revlink_chk u_chk (
  .clk(clk), .rstN(rstN), .laneFault(laneFault), .ovrValid(ovrValid),
  .ovrSel(ovrSel), .txValid(txValid), .txReady(txReady), .laneSel(laneSel),
  .laneTxValid(laneTxValid), .rxValid(rxValid), .capIn(capIn),
  .rOutDbl(rOutDbl), .cfgErr(cfgErr)
);

// File: tb/test_revlink_top.sv
module test_revlink_top;
  localparam int FW = 16;
  localparam int BW = 8;

  logic          clk = 1'b0;
  logic          rstN;
  logic [1:0]    laneFault;
  logic [BW-1:0] availOut, reqOut, usedOut, availIn, reqIn, usedIn;
  logic          ovrValid;
  logic [3:0]    ovrSel;
  logic [1:0]    txValid, txReady, farValid, laneTxValid, rxValid;
  logic [2*FW-1:0] txData, farData, laneTxData, rxData;
  logic [3:0]    laneSel;
  logic [1:0]    capOut, capIn, linkMode;
  logic          rOutDbl, rInDbl, cfgErr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  revlink_top #(.FLIT_W(FW), .BW_W(BW)) i_revlink_top (
    .clk(clk), .rstN(rstN), .laneFault(laneFault),
    .availOut(availOut), .reqOut(reqOut), .usedOut(usedOut),
    .availIn(availIn), .reqIn(reqIn), .usedIn(usedIn),
    .ovrValid(ovrValid), .ovrSel(ovrSel),
    .txValid(txValid), .txData(txData), .txReady(txReady),
    .farValid(farValid), .farData(farData), .laneSel(laneSel),
    .laneTxValid(laneTxValid), .laneTxData(laneTxData),
    .rxValid(rxValid), .rxData(rxData), .capOut(capOut), .capIn(capIn),
    .rOutDbl(rOutDbl), .rInDbl(rInDbl), .linkMode(linkMode), .cfgErr(cfgErr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic idleInputs();
    laneFault = '0; availOut = '0; reqOut = '0; usedOut = '0;
    availIn = '0; reqIn = '0; usedIn = '0; ovrValid = 1'b0; ovrSel = '0;
    txValid = '0; txData = '0; farValid = '0; farData = '0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    idleInputs();
    tick(2);
    rstN = 1'b1;
    tick(1);
  endtask

  task automatic setDir(input logic [1:0] d);
    ovrSel = {~d, d};
    ovrValid = 1'b1;
    tick(1);
    ovrValid = 1'b0;
    tick(4);
  endtask

  function automatic logic [1:0] expDir(input logic [1:0] d, input bit cO,
                                        input bit uIz, input bit cI, input bit uOz);
    logic [1:0] r = d;
    if (cO && uIz && d != 2'b11) begin
      if (!d[0]) r[0] = 1'b1; else r[1] = 1'b1;
    end else if (cI && uOz && d != 2'b00) begin
      if (d[0]) r[0] = 1'b0; else r[1] = 1'b0;
    end
    return r;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1 reset state
    chk("R1 laneSel", laneSel, 4'b1001);
    chk("R1 linkMode", linkMode, 1);
    chk("R1 capOut", capOut, 1);
    chk("R1 capIn", capIn, 1);
    chk("R1 dbl", {rOutDbl, rInDbl}, 0);
    chk("R1 cfgErr", cfgErr, 0);
    chk("R1 txReady", txReady, 2'b01);

    // R9 datapath both directions
    txValid = 2'b01; txData[15:0] = 16'hA5C3;
    farValid = 2'b10; farData[31:16] = 16'h5E71;
    tick(1);
    txValid = '0; farValid = '0;
    chk("R9 laneTxValid", laneTxValid, 2'b01);
    chk("R9 laneTxData", laneTxData[15:0], 16'hA5C3);
    chk("R9 rxValid", rxValid, 2'b10);
    chk("R9 rxData", rxData[31:16], 16'h5E71);
    tick(1);
    chk("R9 drained", {laneTxValid, rxValid}, 0);

    // R3 / R8 / R2 sweep over start direction and condition combos
    for (int sd = 0; sd < 4; sd++) begin
      for (int c = 0; c < 16; c++) begin
        logic [1:0] e;
        setDir(2'(sd));
        chk("R7 override start", laneSel, {~2'(sd), 2'(sd)});
        availOut = c[0] ? 8'd1 : 8'd5; reqOut = 8'd3;
        usedIn   = c[1] ? 8'd0 : 8'd2;
        availIn  = c[2] ? 8'd1 : 8'd5; reqIn = 8'd3;
        usedOut  = c[3] ? 8'd0 : 8'd2;
        tick(1);
        idleInputs();
        tick(4);
        e = expDir(2'(sd), c[0], c[1], c[2], c[3]);
        chk("R3 R2 laneSel", laneSel, {~e, e});
        chk("R8 linkMode", linkMode, 2'(e[0]) + 2'(e[1]));
        chk("R8 capOut", capOut, 2'(e[0]) + 2'(e[1]));
        chk("R8 rOutDbl", rOutDbl, e == 2'b11);
        chk("R8 rInDbl", rInDbl, e == 2'b00);
      end
    end

    // R4 drain with a loaded lane, then turnaround
    doReset();
    txValid = 2'b01; txData[15:0] = 16'h1234;
    availIn = 8'd1; reqIn = 8'd3;
    tick(1);
    idleInputs();
    chk("R4 txReady held", txReady[0], 0);
    chk("R4 flit draining", laneTxValid[0], 1);
    chk("R4 flit data", laneTxData[15:0], 16'h1234);
    // R7 override during a turn is ignored
    ovrSel = 4'b0011; ovrValid = 1'b1;
    tick(1);
    ovrValid = 1'b0;
    chk("R4 still draining", laneSel, 4'b1001);
    chk("R4 lane empty", laneTxValid[0], 0);
    tick(1);
    chk("R4 turnaround", laneSel, 4'b1000);
    tick(1);
    chk("R4 flipped", laneSel, 4'b1100);
    chk("R8 rInDbl", rInDbl, 1);
    tick(4);
    chk("R7 ignored during turn", laneSel, 4'b1100);

    // R4 empty lane: flip two edges after accept
    doReset();
    availOut = 8'd0; reqOut = 8'd4;
    tick(1);
    idleInputs();
    chk("R4 empty drain", laneSel, 4'b1001);
    tick(1);
    chk("R4 empty turn", laneSel, 4'b0001);
    tick(1);
    chk("R4 empty flipped", laneSel, 4'b0011);

    // R5 fault parks lane immediately; R6 blocked by usage
    doReset();
    laneFault = 2'b10; usedOut = 8'd5; farValid = 2'b10;
    #1;
    chk("R5 capIn", capIn, 0);
    chk("R5 capOut", capOut, 1);
    chk("R5 laneSel", laneSel, 4'b0001);
    tick(4);
    chk("R5 rxValid", rxValid[1], 0);
    chk("R6 blocked by usage", laneSel, 4'b0001);
    // R6 takeover beats R3 request
    usedOut = 8'd0; availOut = 8'd0; reqOut = 8'd4;
    tick(2);
    chk("R6 turnaround", laneSel, 4'b0000);
    tick(1);
    availOut = '0; reqOut = '0;
    chk("R6 takeover", laneSel, 4'b0100);
    chk("R6 capIn", capIn, 1);
    chk("R6 capOut", capOut, 0);
    laneFault = 2'b00; farValid = '0;
    #1;
    chk("R5 recovered", laneSel, 4'b1100);
    chk("R5 recovered cap", capIn, 2);

    // R7 illegal override
    tick(1);
    ovrSel = 4'b0101; ovrValid = 1'b1;
    tick(1);
    ovrValid = 1'b0;
    chk("R7 cfgErr", cfgErr, 1);
    tick(1);
    chk("R7 cfgErr pulse", cfgErr, 0);
    tick(3);
    chk("R7 unchanged", laneSel, 4'b1100);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule